// File: doc/BRIEF.md
# Crosspoint Switch Control Register Bank

This block is the host-facing control plane of a 16-by-16 serial crosspoint. A byte-wide bus with a 6-bit address and separate read and write strobes reaches a small register file. Each output has a 4-bit selector that names its source input. Per-channel masks set output enable, forced idle, loopback and resynchronisation. A small register holds a delay field and a self-test bit. The block also holds the crossbar itself: sixteen one-bit lanes, each routed from its selected input.

Synchronisation state and error events come in from the lane logic as plain signals. The four error classes are cell clock, data recovery, threshold and link. Each error is caught in a sticky per-channel bit that clears when the host reads it. Each class can raise a shared interrupt, and each can request a one-cycle resynchronisation of the affected channel. The host polls the status bytes and the error bytes. It writes the selector and mask bytes to set up connections.

Top module: `xpt_ctrl_bank`

## Requirements
- R1: After reset, every selector reads 0xF (address 0x00 reads 0xFF), all masks, enables and error bits are 0, `dout_o`, `irq_o` and `resync_o` are 0.
- R2: Address 0x00+k (k=0..7) holds the selector of output k in bits [3:0] and of output k+8 in bits [7:4], read/write.
- R3: With output j enabled and not idled, `dout_o[j]` equals input lane `sel[j]`, where lane n is bit n of `din_i` (or the loopback value, R5), in the same cycle.
- R4: A clear output-enable bit forces lane j to 0. Otherwise a set force-idle bit forces it to the idle level 1. Masks: force idle 0x10/0x11, output enable 0x14/0x15, loopback 0x16/0x17, resync 0x12/0x13; even address is channels 7..0, odd is 15..8.
- R5: With loopback bit i set, input lane i carries the value `dout_o[i]` had in the previous cycle, and `din_i[i]` has no effect.
- R6: Address 0x08+k reads status of output k in [3:0] and output k+8 in [7:4], where output n's status is `stat_i[4n+3:4n]`.
- R7: Error class c (0 cell, 1 recovery, 2 threshold, 3 link) is read at 0x18+2c (channels 7..0) and 0x19+2c (channels 15..8). A bit sets on an event and holds until its own byte is read. The read clears only that byte. An event in the same cycle as the read leaves the bit set.
- R8: Register 0x20 holds interrupt enables per class in [3:0] and resync enables in [7:4]. `irq_o` is high exactly while some class has an error bit set and its interrupt enable is set.
- R9: When an event sets a previously clear bit i in a class whose resync enable is set, `resync_o[i]` is high for exactly the next cycle. An event on an already set bit gives no pulse.
- R10: Writing a 1 to a resync mask bit pulses `resync_o` for that channel for one cycle after the write. The mask byte reads back as written.
- R11: Mask bytes read back as written. Address 0x21 holds `cell_delay_o` in [3:0] and `bist_o` in bit 4. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (clears error bytes) |
| rdata_o | output | 8 | Read data for addr_i |
| din_i | input | 16 | Input lanes |
| dout_o | output | 16 | Output lanes |
| stat_i | input | 64 | Per-output 4-bit status |
| err_cell_i | input | 16 | Cell clock error events |
| err_dru_i | input | 16 | Data recovery error events |
| err_thr_i | input | 16 | Threshold error events |
| err_link_i | input | 16 | Link error events |
| irq_o | output | 1 | Interrupt |
| resync_o | output | 16 | Per-channel resync pulses |
| cell_delay_o | output | 4 | Cell clock delay field |
| bist_o | output | 1 | Self-test bit |

## Verification
The crossbar is swept through all sixteen rotations of the selector map. Each rotation is driven with walking-one input patterns, which separates a wrong lane from a wrong nibble in the pairing. A many-to-one map where every output takes input 3 exposes selector aliasing. Mixed enable and idle masks separate the priority of the two overrides. Error tests pair single events with byte reads, then repeat an event on a set bit and land an event on the cycle of a read, to tell apart clear scope, clear-versus-set priority and the first-capture resync pulse.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int NCH   = 16;
  localparam int SEL_W = $clog2(NCH);
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int NCLS  = 4;
  localparam int HALF  = NCH / 2;

  localparam logic [AW-1:0] A_SEL  = 6'h00;  // 0x00..0x07
  localparam logic [AW-1:0] A_STAT = 6'h08;  // 0x08..0x0F
  localparam logic [AW-1:0] A_FI   = 6'h10;
  localparam logic [AW-1:0] A_RSY  = 6'h12;
  localparam logic [AW-1:0] A_OE   = 6'h14;
  localparam logic [AW-1:0] A_LB   = 6'h16;
  localparam logic [AW-1:0] A_ERR  = 6'h18;  // 0x18..0x1F, two per class
  localparam logic [AW-1:0] A_EN   = 6'h20;
  localparam logic [AW-1:0] A_MISC = 6'h21;
endpackage

// File: rtl/xpt_xbar.sv
module xpt_xbar
  import xpt_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCH-1:0]             din_i,
  input  logic [NCH-1:0][SEL_W-1:0]  sel_i,
  input  logic [NCH-1:0]             oe_i,
  input  logic [NCH-1:0]             fi_i,
  input  logic [NCH-1:0]             lb_i,
  output logic [NCH-1:0]             dout_o
);
  logic [NCH-1:0] lb_q;
  logic [NCH-1:0] lane;

  // loopback taken from a register to keep the lane path acyclic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lb_q <= '0;
    else         lb_q <= dout_o;
  end

  assign lane = (lb_i & lb_q) | (~lb_i & din_i);

  for (genvar j = 0; j < NCH; j++) begin : g_out
    always_comb begin
      if (!oe_i[j])     dout_o[j] = 1'b0;
      else if (fi_i[j]) dout_o[j] = IDLE_LVL;
      else              dout_o[j] = lane[sel_i[j]];
    end
  end

  p_oe_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((dout_o & ~oe_i) == '0));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((dout_o & oe_i & fi_i) == ({NCH{IDLE_LVL}} & oe_i & fi_i)));
  p_lb_prev_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lane & lb_i) == ($past(dout_o) & lb_i)));
endmodule

// File: rtl/xpt_err_class.sv
module xpt_err_class
  import xpt_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] ev_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] q_o,
  output logic [NCH-1:0] new_o
);
  assign new_o = ev_i & ~q_o;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | ev_i;
  end

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));
  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ev_i) & ~q_o) == '0));
  p_new_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(new_o) & ~q_o) == '0));
endmodule

// File: rtl/xpt_rd_mux.sv
module xpt_rd_mux
  import xpt_pkg::*;
(
  input  logic [AW-1:0]                addr_i,
  input  logic [NCH-1:0][SEL_W-1:0]    sel_i,
  input  logic [4*NCH-1:0]             stat_i,
  input  logic [NCH-1:0]               fi_i,
  input  logic [NCH-1:0]               rsy_i,
  input  logic [NCH-1:0]               oe_i,
  input  logic [NCH-1:0]               lb_i,
  input  logic [NCLS-1:0][NCH-1:0]     err_i,
  input  logic [NCLS-1:0]              ie_i,
  input  logic [NCLS-1:0]              rse_i,
  input  logic [3:0]                   cdel_i,
  input  logic                         bist_i,
  output logic [DW-1:0]                rdata_o
);
  logic [2:0] k;
  logic       hb;
  logic [1:0] c;

  assign k  = addr_i[2:0];
  assign hb = addr_i[0];
  assign c  = addr_i[2:1];

  always_comb begin
    rdata_o = '0;
    if (addr_i[5:3] == A_SEL[5:3]) begin
      rdata_o = {sel_i[4'(k) + 4'(HALF)], sel_i[4'(k)]};
    end else if (addr_i[5:3] == A_STAT[5:3]) begin
      rdata_o = {stat_i[(32'(k) + HALF) * 4 +: 4], stat_i[32'(k) * 4 +: 4]};
    end else if (addr_i[5:1] == A_FI[5:1]) begin
      rdata_o = fi_i[32'(hb) * 8 +: 8];
    end else if (addr_i[5:1] == A_RSY[5:1]) begin
      rdata_o = rsy_i[32'(hb) * 8 +: 8];
    end else if (addr_i[5:1] == A_OE[5:1]) begin
      rdata_o = oe_i[32'(hb) * 8 +: 8];
    end else if (addr_i[5:1] == A_LB[5:1]) begin
      rdata_o = lb_i[32'(hb) * 8 +: 8];
    end else if (addr_i[5:3] == A_ERR[5:3]) begin
      rdata_o = err_i[c][32'(hb) * 8 +: 8];
    end else if (addr_i == A_EN) begin
      rdata_o = {rse_i, ie_i};
    end else if (addr_i == A_MISC) begin
      rdata_o = {3'b000, bist_i, cdel_i};
    end
  end
endmodule

// File: rtl/xpt_ctrl_bank.sv
module xpt_ctrl_bank
  import xpt_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [5:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [7:0]    rdata_o,
  input  logic [15:0]   din_i,
  output logic [15:0]   dout_o,
  input  logic [63:0]   stat_i,
  input  logic [15:0]   err_cell_i,
  input  logic [15:0]   err_dru_i,
  input  logic [15:0]   err_thr_i,
  input  logic [15:0]   err_link_i,
  output logic          irq_o,
  output logic [15:0]   resync_o,
  output logic [3:0]    cell_delay_o,
  output logic          bist_o
);
  logic [NCH-1:0][SEL_W-1:0] sel_q;
  logic [NCH-1:0]            fi_q, rsy_q, oe_q, lb_q;
  logic [NCLS-1:0]           ie_q, rse_q;
  logic [3:0]                cdel_q;
  logic                      bist_q;
  logic [NCLS-1:0][NCH-1:0]  ev, clr, err_q, new_err;
  logic [NCH-1:0]            rsy_wr, rsy_err;
  logic [2:0]                wk;
  logic                      whb;

  assign wk  = addr_i[2:0];
  assign whb = addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= {NCH{SEL_W'(NCH-1)}};
      fi_q   <= '0;
      rsy_q  <= '0;
      oe_q   <= '0;
      lb_q   <= '0;
      ie_q   <= '0;
      rse_q  <= '0;
      cdel_q <= '0;
      bist_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i[5:3] == A_SEL[5:3]) begin
        sel_q[4'(wk)]           <= wdata_i[3:0];
        sel_q[4'(wk) + 4'(HALF)] <= wdata_i[7:4];
      end
      if (addr_i[5:1] == A_FI[5:1])  fi_q[32'(whb) * 8 +: 8]  <= wdata_i;
      if (addr_i[5:1] == A_RSY[5:1]) rsy_q[32'(whb) * 8 +: 8] <= wdata_i;
      if (addr_i[5:1] == A_OE[5:1])  oe_q[32'(whb) * 8 +: 8]  <= wdata_i;
      if (addr_i[5:1] == A_LB[5:1])  lb_q[32'(whb) * 8 +: 8]  <= wdata_i;
      if (addr_i == A_EN) begin
        ie_q  <= wdata_i[3:0];
        rse_q <= wdata_i[7:4];
      end
      if (addr_i == A_MISC) begin
        cdel_q <= wdata_i[3:0];
        bist_q <= wdata_i[4];
      end
    end
  end

  assign ev[0] = err_cell_i;
  assign ev[1] = err_dru_i;
  assign ev[2] = err_thr_i;
  assign ev[3] = err_link_i;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [AW-1:0] a_lo;
    assign a_lo   = A_ERR + AW'(2 * c);
    assign clr[c] = !rd_i              ? '0 :
                    (addr_i == a_lo)    ? {{HALF{1'b0}}, {HALF{1'b1}}} :
                    (addr_i == a_lo + 1) ? {{HALF{1'b1}}, {HALF{1'b0}}} : '0;
    xpt_err_class u_err (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ev_i  (ev[c]),
      .clr_i (clr[c]),
      .q_o   (err_q[c]),
      .new_o (new_err[c])
    );
  end

  always_comb begin
    irq_o   = 1'b0;
    rsy_err = '0;
    for (int c = 0; c < NCLS; c++) begin
      irq_o   = irq_o | (ie_q[c] & (|err_q[c]));
      rsy_err = rsy_err | (new_err[c] & {NCH{rse_q[c]}});
    end
  end

  always_comb begin
    rsy_wr = '0;
    if (wr_i && addr_i[5:1] == A_RSY[5:1]) rsy_wr[32'(whb) * 8 +: 8] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resync_o <= '0;
    else         resync_o <= rsy_wr | rsy_err;
  end

  xpt_xbar #(.IDLE_LVL(IDLE_LVL)) u_xbar (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (din_i),
    .sel_i (sel_q),
    .oe_i  (oe_q),
    .fi_i  (fi_q),
    .lb_i  (lb_q),
    .dout_o(dout_o)
  );

  xpt_rd_mux u_rd (
    .addr_i (addr_i),
    .sel_i  (sel_q),
    .stat_i (stat_i),
    .fi_i   (fi_q),
    .rsy_i  (rsy_q),
    .oe_i   (oe_q),
    .lb_i   (lb_q),
    .err_i  (err_q),
    .ie_i   (ie_q),
    .rse_i  (rse_q),
    .cdel_i (cdel_q),
    .bist_i (bist_q),
    .rdata_o(rdata_o)
  );

  assign cell_delay_o = cdel_q;
  assign bist_o       = bist_q;

  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i && !wr_i) |=> irq_o);
  p_rsy_wr_lo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_RSY) |=> ((resync_o[7:0] & $past(wdata_i)) == $past(wdata_i)));
  p_rsy_wr_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_RSY + 1) |=> ((resync_o[15:8] & $past(wdata_i)) == $past(wdata_i)));
  p_rsy_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && (ev == '0)) |=> (resync_o == '0));
endmodule

// File: tb/tb_xpt_ctrl_bank.sv
module tb_xpt_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] din = '0, dout;
  logic [63:0] stat = '0;
  logic [15:0] e_cell = '0, e_dru = '0, e_thr = '0, e_link = '0;
  logic        irq;
  logic [15:0] rsy;
  logic [3:0]  cdel;
  logic        bist;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  xpt_ctrl_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .din_i(din), .dout_o(dout), .stat_i(stat),
    .err_cell_i(e_cell), .err_dru_i(e_dru), .err_thr_i(e_thr), .err_link_i(e_link),
    .irq_o(irq), .resync_o(rsy), .cell_delay_o(cdel), .bist_o(bist)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 dout", dout, 16'h0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 resync", rsy, 16'h0);
    rreg(6'h00, v); chk("R1 sel", v, 8'hFF);
    rreg(6'h07, v); chk("R1 sel7", v, 8'hFF);
    rreg(6'h14, v); chk("R1 oe", v, 8'h00);
    rreg(6'h1F, v); chk("R1 err", v, 8'h00);

    // R11 mask readback, misc, unmapped
    wreg(6'h14, 8'hFF); wreg(6'h15, 8'hFF);
    rreg(6'h15, v); chk("R11 oe hi", v, 8'hFF);
    wreg(6'h21, 8'h1A);
    chk("R11 cdel", cdel, 4'hA);
    chk("R11 bist", bist, 1'b1);
    rreg(6'h21, v); chk("R11 misc", v, 8'h1A);
    wreg(6'h30, 8'h55); wreg(6'h3F, 8'hAA);
    rreg(6'h30, v); chk("R11 unmapped", v, 8'h00);
    rreg(6'h14, v); chk("R11 oe untouched", v, 8'hFF);
    rreg(6'h21, v); chk("R11 misc untouched", v, 8'h1A);

    // R2 R3 crossbar rotation sweep
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 8; k++)
        wreg(6'(k), {4'((k + 8 + s) % 16), 4'((k + s) % 16)});
      for (int b = 0; b < 16; b++) begin
        @(negedge clk); din = 16'h1 << b;
        exp = '0;
        for (int j = 0; j < 16; j++) exp[j] = din[(j + s) % 16];
        #2 chk("R3 rotate", dout, exp);
      end
    end
    rreg(6'h03, v); chk("R2 sel pair", v, 8'hA2);
    wreg(6'h05, 8'h9C);
    rreg(6'h05, v); chk("R2 sel rw", v, 8'h9C);

    // R3 many-to-one, R4 priority
    for (int k = 0; k < 8; k++) wreg(6'(k), 8'h33);
    @(negedge clk); din = 16'h0008; #2 chk("R3 fanout", dout, 16'hFFFF);
    wreg(6'h14, 8'h0F); wreg(6'h10, 8'h03); wreg(6'h11, 8'h80);
    rreg(6'h11, v); chk("R11 fi hi", v, 8'h80);
    @(negedge clk); din = 16'h0000; #2 chk("R4 idle over zero", dout, 16'h8003);
    @(negedge clk); din = 16'h0008; #2 chk("R4 oe mask", dout, 16'hFF0F);
    wreg(6'h10, 8'h00); wreg(6'h11, 8'h00); wreg(6'h14, 8'hFF);

    // R5 loopback on channel 2
    wreg(6'h02, 8'h07);  // out2 <- in7
    wreg(6'h00, 8'h02);  // out0 <- in2
    wreg(6'h16, 8'h04);
    rreg(6'h16, v); chk("R11 lb lo", v, 8'h04);
    @(negedge clk); din = 16'h0080;
    @(negedge clk); @(negedge clk);
    #2 chk("R5 out2", dout[2], 1'b1);
    chk("R5 loop to out0", dout[0], 1'b1);
    @(negedge clk); din = 16'h0004;
    #2 chk("R5 out2 low", dout[2], 1'b0);
    chk("R5 out0 delayed", dout[0], 1'b1);
    @(negedge clk); #2 chk("R5 ext lane ignored", dout[0], 1'b0);
    wreg(6'h16, 8'h00);

    // R6 status pairing
    stat = 64'h0123456789ABCDEF;
    for (int k = 0; k < 8; k++) begin
      rreg(6'(8 + k), v);
      chk("R6 status", v, {stat[(k + 8) * 4 +: 4], stat[k * 4 +: 4]});
    end
    stat = 64'hF0E1D2C3B4A59687;
    for (int k = 0; k < 8; k++) begin
      rreg(6'(8 + k), v);
      chk("R6 status b", v, {stat[(k + 8) * 4 +: 4], stat[k * 4 +: 4]});
    end

    // R10 resync mask write pulse
    wreg(6'h13, 8'h81);
    chk("R10 pulse", rsy, 16'h8100);
    @(negedge clk); chk("R10 one cycle", rsy, 16'h0000);
    rreg(6'h13, v); chk("R10 readback", v, 8'h81);

    // R8 R9 threshold class, irq+resync enabled
    wreg(6'h20, 8'h44);
    rreg(6'h20, v); chk("R8 enables", v, 8'h44);
    @(negedge clk); e_thr = 16'h0200;
    @(negedge clk); e_thr = 16'h0000;
    chk("R9 resync pulse", rsy, 16'h0200);
    chk("R8 irq set", irq, 1'b1);
    @(negedge clk); chk("R9 pulse ends", rsy, 16'h0000);
    @(negedge clk); e_thr = 16'h0200;
    @(negedge clk); e_thr = 16'h0000;
    chk("R9 no repulse", rsy, 16'h0000);
    repeat (3) @(negedge clk);
    rreg(6'h1C, v); chk("R7 thr lo", v, 8'h00);
    chk("R8 irq held", irq, 1'b1);
    rreg(6'h1D, v); chk("R7 thr hi", v, 8'h02);
    chk("R8 irq clear", irq, 1'b0);
    rreg(6'h1D, v); chk("R7 cleared", v, 8'h00);

    // R7 link class: byte-local clear, no irq, no resync
    @(negedge clk); e_link = 16'h0101;
    @(negedge clk); e_link = 16'h0000;
    chk("R8 masked class", irq, 1'b0);
    chk("R9 disabled class", rsy, 16'h0000);
    rreg(6'h1E, v); chk("R7 link lo", v, 8'h01);
    rreg(6'h1F, v); chk("R7 hi kept", v, 8'h01);
    rreg(6'h1E, v); chk("R7 lo clear", v, 8'h00);
    // event on the read cycle wins
    @(negedge clk); addr = 6'h1E; rd = 1'b1; e_link = 16'h0001;
    @(negedge clk); rd = 1'b0; e_link = 16'h0000;
    rreg(6'h1E, v); chk("R7 set wins", v, 8'h01);

    // R7 cell and recovery class mapping
    @(negedge clk); e_cell = 16'h0008; e_dru = 16'h1000;
    @(negedge clk); e_cell = 16'h0000; e_dru = 16'h0000;
    rreg(6'h18, v); chk("R7 cell lo", v, 8'h08);
    rreg(6'h1B, v); chk("R7 dru hi", v, 8'h10);
    rreg(6'h1A, v); chk("R7 dru lo", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule